// File: doc/BRIEF.md
# Frequency-Locked Loop Lock Detector

This block judges whether a digital frequency-locked loop has reached its target frequency. Over each comparison cycle it counts the pulses of the controlled oscillator. When the comparison strobe arrives, it subtracts that count from a programmed multiplier target, which gives a signed count error. A two-window hysteresis test turns the stream of count errors into a lock flag. A narrow window and a run of good samples are needed to gain lock. After lock is gained, only an error outside a wider window drops it.

Some events drop lock on purpose: a new target, a mode or trim change, or a planned stop. These clear the lock flag and leave the sticky loss flag alone. A loss of lock that nothing commanded sets the sticky flag, and so does a stop of clocks that was not planned. The flag stays set until software clears it. The block also feeds the loop filter. While unlocked it sends every raw error. While locked it sends the average of four errors once every four samples. It also tells the output clock path to add a divide by two from the moment the loop is engaged until the first lock.

Top module: `fll_lock_monitor`

## Requirements
- R1: The count error is the target minus the number of oscillator pulses seen since the previous comparison strobe, the strobe cycle included. It is a two's-complement value of width CW+2. It appears on `filt_err` together with a one-cycle `filt_upd` pulse two clock edges after the edge that samples `cmp_strobe` high.
- R2: While unlocked, `lock` rises after LOCK_CNT (default 3) consecutive count errors inside the lock window [LOCK_MIN, LOCK_MAX] (default [-2, 2], bounds included).
- R3: A count error outside the lock window while unlocked restarts the consecutive-sample count from zero.
- R4: While locked, `lock` stays high for any count error inside the unlock window [UNLOCK_MIN, UNLOCK_MAX] (default [-6, 6], bounds included). It falls on the first error outside that window.
- R5: A loss of lock under R4 sets `lost_sticky`. A one-cycle `sw_clear` pulse clears it. If a set and a clear fall on the same edge, the set wins.
- R6: A change of `target`, or a `mode_chg` pulse, clears `lock` on the next edge and restarts acquisition. It does not touch `lost_sticky`.
- R7: While `stop_planned` is high, `lock` is low, no comparison produces a filter update, and `lost_sticky` keeps its value.
- R8: While `stop_unplanned` is high, the block behaves as under R7. On the edge after `stop_unplanned` falls, `lost_sticky` sets.
- R9: While locked and staying locked, `filt_upd` pulses once every four comparisons. `filt_err` then carries the sum of those four errors shifted right arithmetically by two. The four-sample group restarts on every change of `lock`.
- R10: Every comparison that is not averaged under R9 gives a `filt_upd` pulse that carries the raw count error. This covers every unlocked sample, the sample that gains lock and the sample that loses it.
- R11: `div2_sel` is high while `engage` is high and no lock has been seen since `engage` last rose. It stays low through later losses of lock. It is low while `engage` is low.
- R12: After reset, `lock`, `lost_sticky`, `filt_upd` and `div2_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_pulse | input | 1 | One-cycle pulse per oscillator period |
| cmp_strobe | input | 1 | Marks the last cycle of a comparison cycle |
| target | input | CW | Expected pulse count per comparison cycle |
| mode_chg | input | 1 | Pulse for a clock-select or trim change |
| engage | input | 1 | Loop is in the engaged mode |
| stop_planned | input | 1 | Planned stop is in force |
| stop_unplanned | input | 1 | Clocks have stopped without a plan |
| sw_clear | input | 1 | One-cycle clear of the sticky loss flag |
| lock | output | 1 | Loop is in lock |
| lost_sticky | output | 1 | An unexpected loss of lock has occurred |
| filt_upd | output | 1 | One-cycle filter update strobe |
| filt_err | output | CW+2 | Signed error for the filter update |
| div2_sel | output | 1 | Add a divide by two to the output clock |

## Verification
Errors are fed in a series that places one out-of-window sample between runs of good samples. This series separates a streak counter that restarts from one that merely pauses. The exact boundary values ±2 and ±7 and a ±6 sample are used to separate the narrow lock window from the wide unlock window. A locked group of four errors with a negative, non-multiple-of-four sum shows the difference between an arithmetic shift and truncation or a plain sample. Target changes, mode pulses and both kinds of stop are each applied on a locked loop. This shows which of them set the sticky flag, and a clear that coincides with a loss shows which of the two wins.

// File: rtl/fll_lock_pkg.sv
package fll_lock_pkg;

  typedef enum logic {
    TRK_ACQUIRE = 1'b0,
    TRK_HOLD    = 1'b1
  } trk_state_e;

  function automatic logic in_window(input logic signed [31:0] v,
                                     input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/fll_pulse_counter.sv
module fll_pulse_counter #(
  parameter int CW = 8,
  localparam int EW = CW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pulse_i,
  input  logic                 strobe_i,
  input  logic                 flush_i,
  input  logic [CW-1:0]        target_i,
  output logic                 err_vld_o,
  output logic signed [EW-1:0] err_o
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0]        cnt_q, cnt_n, cnt_inc;
  logic                 vld_q, vld_n;
  logic signed [EW-1:0] err_q, err_n;
  logic                 err_en;

  always_comb begin
    cnt_inc = (pulse_i && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
    if (flush_i || strobe_i) cnt_n = '0;
    else                     cnt_n = cnt_inc;
    vld_n  = strobe_i && !flush_i;
    err_en = vld_n;
    err_n  = $signed({2'b00, target_i}) - $signed({2'b00, cnt_inc});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_n;
  end

  assign err_vld_o = vld_q;
  assign err_o     = err_q;

  // R1
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !err_vld_o);

endmodule

// File: rtl/fll_lock_tracker.sv
module fll_lock_tracker
  import fll_lock_pkg::*;
#(
  parameter int EW         = 10,
  parameter int LOCK_MIN   = -2,
  parameter int LOCK_MAX   = 2,
  parameter int UNLOCK_MIN = -6,
  parameter int UNLOCK_MAX = 6,
  parameter int LOCK_CNT   = 3,
  localparam int SW        = $clog2(LOCK_CNT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld_i,
  input  logic signed [EW-1:0] smp_err_i,
  input  logic                 drop_i,
  output logic                 lock_o,
  output logic                 loss_o,
  output logic                 avg_mode_o,
  output logic                 restart_o
);

  trk_state_e    st_q, st_n;
  logic [SW-1:0] streak_q, streak_n;
  logic          in_lk, in_ul, loss_n;

  always_comb begin
    in_lk    = in_window(32'(smp_err_i), LOCK_MIN, LOCK_MAX);
    in_ul    = in_window(32'(smp_err_i), UNLOCK_MIN, UNLOCK_MAX);
    st_n     = st_q;
    streak_n = streak_q;
    loss_n   = 1'b0;
    if (drop_i) begin
      st_n     = TRK_ACQUIRE;
      streak_n = '0;
    end else if (smp_vld_i) begin
      case (st_q)
        TRK_ACQUIRE: begin
          if (!in_lk) begin
            streak_n = '0;
          end else if (streak_q == SW'(LOCK_CNT - 1)) begin
            st_n     = TRK_HOLD;
            streak_n = '0;
          end else begin
            streak_n = streak_q + 1'b1;
          end
        end
        default: begin
          if (!in_ul) begin
            st_n   = TRK_ACQUIRE;
            loss_n = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= TRK_ACQUIRE;
      streak_q <= '0;
    end else begin
      st_q     <= st_n;
      streak_q <= streak_n;
    end
  end

  assign lock_o     = (st_q == TRK_HOLD);
  assign loss_o     = loss_n;
  assign avg_mode_o = (st_q == TRK_HOLD) && (st_n == TRK_HOLD) && smp_vld_i;
  assign restart_o  = (st_q != st_n);

  // R2
  lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(smp_vld_i && in_lk));

  // R4
  unlock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && smp_vld_i && !in_ul) |=> !lock_o);

  // R6
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> !lock_o);

endmodule

// File: rtl/fll_err_averager.sv
module fll_err_averager #(
  parameter int EW = 10,
  localparam int AW = EW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld_i,
  input  logic signed [EW-1:0] smp_err_i,
  input  logic                 avg_mode_i,
  input  logic                 restart_i,
  output logic                 upd_o,
  output logic signed [EW-1:0] upd_err_o
);

  logic signed [AW-1:0] acc_q, acc_n, sum;
  logic [1:0]           n_q, n_n;
  logic                 upd_q, upd_n;
  logic signed [EW-1:0] out_q, out_n;

  always_comb begin
    sum   = acc_q + AW'(smp_err_i);
    acc_n = acc_q;
    n_n   = n_q;
    upd_n = 1'b0;
    out_n = out_q;
    if (smp_vld_i && avg_mode_i) begin
      if (n_q == 2'd3) begin
        upd_n = 1'b1;
        out_n = EW'(sum >>> 2);
        acc_n = '0;
        n_n   = '0;
      end else begin
        acc_n = sum;
        n_n   = n_q + 1'b1;
      end
    end else if (smp_vld_i) begin
      upd_n = 1'b1;
      out_n = smp_err_i;
    end
    if (restart_i) begin
      acc_n = '0;
      n_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      n_q   <= '0;
      upd_q <= 1'b0;
      out_q <= '0;
    end else begin
      acc_q <= acc_n;
      n_q   <= n_n;
      upd_q <= upd_n;
      out_q <= out_n;
    end
  end

  assign upd_o     = upd_q;
  assign upd_err_o = out_q;

  // R10
  raw_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && !avg_mode_i) |=> (upd_o && (upd_err_o == $past(smp_err_i))));

  // R9
  no_spurious_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> !upd_o);

endmodule

// File: rtl/fll_loss_flag.sv
module fll_loss_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic loss_i,
  input  logic stop_unpl_i,
  input  logic clr_i,
  output logic sticky_o
);

  logic stop_q;
  logic sticky_q, sticky_n;
  logic set_evt;

  always_comb begin
    set_evt = loss_i || (stop_q && !stop_unpl_i);
    if (set_evt)    sticky_n = 1'b1;
    else if (clr_i) sticky_n = 1'b0;
    else            sticky_n = sticky_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      stop_q   <= stop_unpl_i;
      sticky_q <= sticky_n;
    end
  end

  assign sticky_o = sticky_q;

  // R5
  loss_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss_i |=> sticky_o);

  // R8
  resume_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_unpl_i) |=> sticky_o);

endmodule

// File: rtl/fll_lock_monitor.sv
module fll_lock_monitor #(
  parameter int CW         = 8,
  parameter int LOCK_MIN   = -2,
  parameter int LOCK_MAX   = 2,
  parameter int UNLOCK_MIN = -6,
  parameter int UNLOCK_MAX = 6,
  parameter int LOCK_CNT   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_pulse,
  input  logic                 cmp_strobe,
  input  logic [CW-1:0]        target,
  input  logic                 mode_chg,
  input  logic                 engage,
  input  logic                 stop_planned,
  input  logic                 stop_unplanned,
  input  logic                 sw_clear,
  output logic                 lock,
  output logic                 lost_sticky,
  output logic                 filt_upd,
  output logic signed [CW+1:0] filt_err,
  output logic                 div2_sel
);

  localparam int EW = CW + 2;

  logic [CW-1:0]        target_q;
  logic                 halt, exp_evt, flush;
  logic                 err_vld, smp_vld;
  logic signed [EW-1:0] err;
  logic                 lock_w, loss_w, avg_mode_w, restart_w;
  logic                 seen_q, seen_n;

  always_comb begin
    halt    = stop_planned || stop_unplanned;
    exp_evt = mode_chg || (target != target_q);
    flush   = halt || exp_evt;
    smp_vld = err_vld && !flush;
    seen_n  = engage && (seen_q || lock_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      target_q <= target;
      seen_q   <= seen_n;
    end
  end

  fll_pulse_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_i   (osc_pulse),
    .strobe_i  (cmp_strobe),
    .flush_i   (flush),
    .target_i  (target),
    .err_vld_o (err_vld),
    .err_o     (err)
  );

  fll_lock_tracker #(
    .EW(EW), .LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX),
    .UNLOCK_MIN(UNLOCK_MIN), .UNLOCK_MAX(UNLOCK_MAX), .LOCK_CNT(LOCK_CNT)
  ) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld_i  (smp_vld),
    .smp_err_i  (err),
    .drop_i     (flush),
    .lock_o     (lock_w),
    .loss_o     (loss_w),
    .avg_mode_o (avg_mode_w),
    .restart_o  (restart_w)
  );

  fll_err_averager #(.EW(EW)) u_avg (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld_i  (smp_vld),
    .smp_err_i  (err),
    .avg_mode_i (avg_mode_w),
    .restart_i  (restart_w),
    .upd_o      (filt_upd),
    .upd_err_o  (filt_err)
  );

  fll_loss_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .loss_i      (loss_w),
    .stop_unpl_i (stop_unplanned),
    .clr_i       (sw_clear),
    .sticky_o    (lost_sticky)
  );

  assign lock     = lock_w;
  assign div2_sel = engage && !seen_q && !lock_w;

  // R7
  stop_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> !lock);

  // R11
  div2_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engage && $past(engage) && $past(lock)) |-> !div2_sel);

endmodule

// File: tb/fll_lock_monitor_bench.sv
module fll_lock_monitor_bench;

  localparam int CW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 osc_pulse, cmp_strobe, mode_chg, engage;
  logic                 stop_planned, stop_unplanned, sw_clear;
  logic [CW-1:0]        target;
  logic                 lock, lost_sticky, filt_upd, div2_sel;
  logic signed [CW+1:0] filt_err;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  fll_lock_monitor #(.CW(CW)) u_fll_lock_monitor (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .cmp_strobe(cmp_strobe),
    .target(target), .mode_chg(mode_chg), .engage(engage),
    .stop_planned(stop_planned), .stop_unplanned(stop_unplanned),
    .sw_clear(sw_clear), .lock(lock), .lost_sticky(lost_sticky),
    .filt_upd(filt_upd), .filt_err(filt_err), .div2_sel(div2_sel)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // n pulses, then a strobe cycle; returns at the negedge where results show
  task automatic run(input int n, input bit clr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_pulse = 1'b1;
    end
    @(negedge clk); osc_pulse = 1'b0; cmp_strobe = 1'b1;
    @(negedge clk); cmp_strobe = 1'b0; sw_clear = clr;
    @(negedge clk); sw_clear = 1'b0;
  endtask

  task automatic acquire();
    run(100, 0); run(100, 0); run(100, 0);
  endtask

  task automatic clear_sticky();
    @(negedge clk); sw_clear = 1'b1;
    @(negedge clk); sw_clear = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; osc_pulse = 0; cmp_strobe = 0; mode_chg = 0; engage = 0;
    stop_planned = 0; stop_unplanned = 0; sw_clear = 0; target = 8'd100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 lock", lock, 0);
    chk("R12 sticky", lost_sticky, 0);
    chk("R12 upd", filt_upd, 0);
    chk("R12 div2", div2_sel, 0);
    engage = 1'b1;
    @(negedge clk);
    chk("R11 div2 on engage", div2_sel, 1);
  endtask

  task automatic t_raw();
    run(90, 0);
    chk("R1 upd", filt_upd, 1);
    chk("R1 err +10", filt_err, 10);
    chk("R10 lock low", lock, 0);
    run(103, 0);
    chk("R10 upd", filt_upd, 1);
    chk("R10 err -3", filt_err, -3);
    @(negedge clk);
    chk("R1 upd one cycle", filt_upd, 0);
  endtask

  task automatic t_acquire();
    run(101, 0); run(99, 0);
    chk("R2 lock after two", lock, 0);
    run(97, 0);
    chk("R3 lock after outlier", lock, 0);
    chk("R3 raw +3", filt_err, 3);
    run(100, 0); run(102, 0);
    chk("R3 streak restarted", lock, 0);
    run(98, 0);
    chk("R2 lock gained", lock, 1);
    chk("R10 lock sample raw", filt_err, 2);
    chk("R11 div2 off", div2_sel, 0);
  endtask

  task automatic t_average();
    run(106, 0);
    chk("R4 hold at -6", lock, 1);
    chk("R9 no upd 1", filt_upd, 0);
    run(96, 0);
    chk("R9 no upd 2", filt_upd, 0);
    run(105, 0);
    chk("R9 no upd 3", filt_upd, 0);
    run(102, 0);
    chk("R9 upd 4", filt_upd, 1);
    chk("R9 avg -9>>>2", filt_err, -3);
    chk("R4 still locked", lock, 1);
    run(107, 0);
    chk("R4 lock lost at -7", lock, 0);
    chk("R5 sticky set", lost_sticky, 1);
    chk("R10 loss sample raw", filt_err, -7);
    chk("R11 div2 stays off", div2_sel, 0);
  endtask

  task automatic t_clear();
    clear_sticky();
    chk("R5 cleared", lost_sticky, 0);
    acquire();
    chk("R2 relock", lock, 1);
    run(93, 1);
    chk("R5 set wins", lost_sticky, 1);
    chk("R4 lost at +7", lock, 0);
  endtask

  task automatic t_expected();
    clear_sticky();
    acquire();
    @(negedge clk); target = 8'd101;
    @(negedge clk);
    chk("R6 target change lock", lock, 0);
    chk("R6 target change sticky", lost_sticky, 0);
    target = 8'd100;
    acquire();
    chk("R6 relock", lock, 1);
    mode_chg = 1'b1;
    @(negedge clk); mode_chg = 1'b0;
    chk("R6 mode lock", lock, 0);
    chk("R6 mode sticky", lost_sticky, 0);
  endtask

  task automatic t_stop();
    acquire();
    @(negedge clk); stop_planned = 1'b1;
    @(negedge clk);
    chk("R7 stop lock", lock, 0);
    chk("R7 stop sticky kept 0", lost_sticky, 0);
    run(90, 0);
    chk("R7 no update", filt_upd, 0);
    stop_planned = 1'b0;
    @(negedge clk); stop_unplanned = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 sticky while stopped", lost_sticky, 0);
    stop_unplanned = 1'b0;
    @(negedge clk);
    chk("R8 sticky on resume", lost_sticky, 1);
    stop_planned = 1'b1;
    repeat (2) @(negedge clk);
    stop_planned = 1'b0;
    @(negedge clk);
    chk("R7 stop sticky kept 1", lost_sticky, 1);
  endtask

  task automatic t_reengage();
    engage = 1'b0;
    @(negedge clk);
    chk("R11 div2 low when off", div2_sel, 0);
    engage = 1'b1;
    @(negedge clk);
    chk("R11 div2 on re-engage", div2_sel, 1);
  endtask

  initial begin
    t_reset();
    t_raw();
    t_acquire();
    t_average();
    t_clear();
    t_expected();
    t_stop();
    t_reengage();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule